// File: doc/BRIEF.md
# PPP Address/Control Field Filter

This block sits in a receive byte path just after frame delimiting and destuffing. It looks at the first two bytes of every frame, the address and control fields, and can hold the frame to the fixed values 0xFF (all-stations address) and 0x03 (unnumbered information command with the poll/final bit clear). When checking is on and a frame fails this test, every byte of that frame is thrown away and a maskable one-cycle interrupt pulse reports the drop. Frames that are kept leave either with the two header bytes intact or with them removed, as chosen by a pass control.

The two header bytes are held inside the block until the keep/drop decision is made. This way no byte of a frame that will be dropped ever reaches the output. Past the header, payload bytes go straight from input to output with no added latency. Back-pressure follows valid/ready: a byte moves on a rising edge when both valid and ready are high. A source holds `in_data`, `in_sof` and `in_eof` steady while `in_valid` is high and `in_ready` is low, and the block gives the same promise on its output. The configuration inputs are plain levels. They are read at the moment the header is judged and must be held steady while a frame's header is being received.

Top module: `acf_filter`

## Requirements
- R1: With checking on, a frame whose first byte is 0xFF and second byte is 0x03 is kept, and its bytes leave in input order.
- R2: With checking on, a frame with a first byte other than 0xFF or a second byte other than 0x03 is dropped whole; no byte of it appears at the output.
- R3: For each frame dropped by the check, `drop_irq` is high for exactly one cycle: the cycle after the edge that accepted the deciding byte (the second byte, or the only byte of a one-byte frame), and only if `irq_mask` was 0 at that edge. Otherwise `drop_irq` stays 0.
- R4: For a kept frame, `pass_en`=1 forwards the two header bytes, with `out_sof` on the address byte. `pass_en`=0 removes them, and `out_sof` moves to the third input byte.
- R5: With checking off, every frame is kept whatever its header bytes hold, and no interrupt is raised.
- R6: With checking on, a frame that ends (`in_eof`) before its second byte counts as a mismatch: it is dropped and reported as in R2 and R3.
- R7: No output appears while a frame's header is still being collected: after the first byte of a frame is accepted and before its second arrives, `out_valid` is 0.
- R8: Stream rules: a frame's first input byte carries `in_sof`; `out_valid` with its data and `out_eof` stays unchanged while `out_ready` is low; `in_ready` is 1 after reset and while collecting a header or discarding.
- R9: A kept frame of one or two bytes, with checking off, is forwarded whole with `out_sof` on its first and `out_eof` on its last byte when `pass_en`=1, and produces no output when `pass_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first forwarded byte of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| chk_en | input | 1 | Enable address/control checking |
| pass_en | input | 1 | Forward (1) or strip (0) the header bytes |
| irq_mask | input | 1 | Suppress the drop interrupt when 1 |
| drop_irq | output | 1 | One-cycle pulse per dropped frame |

## Verification
Payload bytes are combinational from input to output, so the bench drives just after a rising edge and samples at the falling edge before the handshake edge. It compares each output handshake against a queue of expected bytes built by a frame model. The held header bytes appear only in the cycles after the deciding byte's edge, and the queue makes the exact cycle irrelevant. The interrupt is due one cycle after the deciding handshake: the bench idles the input for that cycle and reads `drop_irq` at its falling edge. It also tallies every pulse and matches the total against the expected count at the end. R7 is sampled at the falling edge between the first and second header handshakes.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HDR_N  = 2;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_EMIT,
    ST_BODY,
    ST_DROP
  } acf_state_e;
endpackage

// File: rtl/acf_hold_buf.sv
module acf_hold_buf #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [N*W-1:0]   q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i*W +: W] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i)) q[i*W +: W] <= wr_data;
    end
  end
endmodule

// File: rtl/acf_hdr_cmp.sv
module acf_hdr_cmp #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2,
  parameter logic [N*W-1:0] EXP = '1,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0]   held,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [W-1:0]     cur_data,
  output logic             match
);
  logic [N-1:0] eq;
  for (genvar i = 0; i < N; i++) begin : g_byte
    logic [W-1:0] cand;
    assign cand  = (cur_idx == IDX_W'(i)) ? cur_data : held[i*W +: W];
    assign eq[i] = (cand == EXP[i*W +: W]);
  end
  assign match = &eq;
endmodule

// File: rtl/acf_filter.sv
module acf_filter
  import acf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_VAL = 8'hFF,
  parameter logic [BYTE_W-1:0] CTRL_VAL = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  input  logic              chk_en,
  input  logic              pass_en,
  input  logic              irq_mask,
  output logic              drop_irq
);
  localparam int unsigned IDX_W = (HDR_N > 1) ? $clog2(HDR_N) : 1;
  localparam logic [HDR_N*BYTE_W-1:0] HDR_EXP = {CTRL_VAL, ADDR_VAL};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_N - 1);

  acf_state_e state;
  logic [IDX_W-1:0] hdr_cnt, emit_idx, emit_end;
  logic emit_eof, first_body;
  logic [HDR_N*BYTE_W-1:0] hold_q;
  logic cmp_match, hdr_take, hdr_final, short_frm, mismatch, drop_now;
  logic hs_in, hs_out;

  acf_hold_buf #(.W(BYTE_W), .N(HDR_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(hdr_take), .wr_idx(hdr_cnt),
    .wr_data(in_data), .q(hold_q)
  );

  acf_hdr_cmp #(.W(BYTE_W), .N(HDR_N), .EXP(HDR_EXP)) u_cmp (
    .held(hold_q), .cur_idx(hdr_cnt), .cur_data(in_data), .match(cmp_match)
  );

  assign hdr_take  = (state == ST_HDR) && in_valid;
  assign short_frm = in_eof && (hdr_cnt != LAST_IDX);
  assign hdr_final = hdr_take && ((hdr_cnt == LAST_IDX) || in_eof);
  assign mismatch  = chk_en && (short_frm || !cmp_match);
  assign drop_now  = hdr_final && mismatch;
  assign hs_in     = in_valid && in_ready;
  assign hs_out    = out_valid && out_ready;

  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = '0;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    unique case (state)
      ST_EMIT: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = hold_q[emit_idx*BYTE_W +: BYTE_W];
        out_sof   = (emit_idx == '0);
        out_eof   = emit_eof && (emit_idx == emit_end);
      end
      ST_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_sof   = first_body;
        out_eof   = in_eof;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HDR;
      hdr_cnt    <= '0;
      emit_idx   <= '0;
      emit_end   <= '0;
      emit_eof   <= 1'b0;
      first_body <= 1'b0;
      drop_irq   <= 1'b0;
    end else begin
      drop_irq <= drop_now && !irq_mask;
      unique case (state)
        ST_HDR: if (hdr_take) begin
          if (!hdr_final) begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end else begin
            hdr_cnt <= '0;
            if (mismatch) begin
              state <= in_eof ? ST_HDR : ST_DROP;
            end else if (pass_en) begin
              state    <= ST_EMIT;
              emit_idx <= '0;
              emit_end <= hdr_cnt;
              emit_eof <= in_eof;
            end else if (!in_eof) begin
              state      <= ST_BODY;
              first_body <= 1'b1;
            end
          end
        end
        ST_EMIT: if (hs_out) begin
          if (emit_idx == emit_end) begin
            emit_idx   <= '0;
            first_body <= 1'b0;
            state      <= emit_eof ? ST_HDR : ST_BODY;
          end else begin
            emit_idx <= emit_idx + 1'b1;
          end
        end
        ST_BODY: if (hs_out) begin
          first_body <= 1'b0;
          if (in_eof) state <= ST_HDR;
        end
        ST_DROP: if (hs_in && in_eof) state <= ST_HDR;
        default: state <= ST_HDR;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof)); // R8
  AST_SOF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hs_in && state == ST_HDR && hdr_cnt == '0 |-> in_sof); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_irq |-> $past(drop_now && !irq_mask)); // R3
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drop_now) |-> !out_valid); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_EMIT |=> $stable(hold_q)); // R7
endmodule

// File: tb/acf_filter_test.sv
module acf_filter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_sof, in_eof, out_valid, out_ready;
  logic out_sof, out_eof, chk_en, pass_en, irq_mask, drop_irq;
  logic [7:0] in_data, out_data;

  acf_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .chk_en(chk_en), .pass_en(pass_en),
    .irq_mask(irq_mask), .drop_irq(drop_irq)
  );

  int checks = 0, fails = 0, irq_seen = 0, irq_exp = 0;
  logic [9:0] exp_q[$];
  logic [7:0] frm[$];
  bit rand_ready = 1'b0;
  string cur_req = "R1";
  bit hold_pend = 1'b0;
  logic [7:0] hold_d;
  logic hold_e;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1 out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (drop_irq) irq_seen++;
    if (hold_pend)
      chk(out_valid && out_data == hold_d && out_eof == hold_e, "R8", "held output",
          {out_valid, out_eof, out_data}, {1'b1, hold_e, hold_d});
    hold_pend = out_valid && !out_ready;
    hold_d = out_data;
    hold_e = out_eof;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected output", {out_sof, out_eof, out_data}, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({out_sof, out_eof, out_data} == e, cur_req, "output byte",
            {out_sof, out_eof, out_data}, e);
      end
    end
  end

  function automatic bit model(bit c, bit p);
    int n = frm.size();
    bit ok = (n >= 2) && frm[0] == 8'hFF && frm[1] == 8'h03;
    int st;
    if (c && !ok) return 1'b1;
    if (n <= 2 && !p) return 1'b0;
    st = p ? 0 : 2;
    for (int i = st; i < n; i++) exp_q.push_back({i == st, i == n - 1, frm[i]});
    return 1'b0;
  endfunction

  task automatic send_frame(bit c, bit p, bit m, string req);
    int n = frm.size();
    int dec = (n >= 2) ? 1 : 0;
    bit drop, r, ex;
    chk_en = c; pass_en = p; irq_mask = m; cur_req = req;
    drop = model(c, p);
    for (int i = 0; i < n; i++) begin
      bit first = 1'b1;
      in_valid = 1'b1; in_data = frm[i]; in_sof = (i == 0); in_eof = (i == n - 1);
      do begin
        @(negedge clk);
        r = in_ready;
        if (i == 1 && first) chk(!out_valid, "R7", "output during header", out_valid, 0);
        first = 1'b0;
        @(posedge clk);
      end while (!r);
      #1;
      if (i == dec) begin
        in_valid = 1'b0;
        @(negedge clk);
        ex = drop && !m;
        chk(drop_irq == ex, (n < 2) ? "R6" : "R3", "irq after decision", drop_irq, ex);
        if (ex) irq_exp++;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, cur_req, "bytes missing", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    chk_en = 1'b1; pass_en = 1'b1; irq_mask = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R7", "reset out_valid", out_valid, 0);
    chk(!drop_irq, "R3", "reset irq", drop_irq, 0);
    chk(in_ready, "R8", "reset in_ready", in_ready, 1);
    @(posedge clk); #1;

    frm = '{8'hFF, 8'h03, 8'h00, 8'h21, 8'h45}; send_frame(1, 1, 0, "R1"); drain();
    frm = '{8'hFF, 8'h03, 8'hC0, 8'h21, 8'h01}; send_frame(1, 0, 0, "R4"); drain();
    frm = '{8'hFE, 8'h03, 8'h11, 8'h22};        send_frame(1, 1, 0, "R2"); drain();
    frm = '{8'hFF, 8'h13, 8'h11};               send_frame(1, 0, 0, "R2"); drain();
    frm = '{8'h00, 8'h00, 8'h55, 8'h66};        send_frame(1, 1, 1, "R3"); drain();
    frm = '{8'h12, 8'h34, 8'h56, 8'h78};        send_frame(0, 1, 0, "R5"); drain();
    frm = '{8'hAB, 8'hCD, 8'hEF};               send_frame(0, 0, 0, "R5"); drain();
    frm = '{8'hFF};                             send_frame(1, 1, 0, "R6"); drain();
    frm = '{8'h77};                             send_frame(0, 1, 0, "R9"); drain();
    frm = '{8'h9A, 8'hBC};                      send_frame(0, 1, 0, "R9"); drain();
    frm = '{8'hFF, 8'h03};                      send_frame(0, 0, 0, "R9"); drain();
    frm = '{8'hFF, 8'h03};                      send_frame(1, 1, 0, "R9"); drain();

    rand_ready = 1'b1;
    for (int f = 0; f < 250; f++) begin
      int n = 1 + ($urandom % 8);
      bit good = ($urandom % 10) < 7;
      frm = {};
      for (int i = 0; i < n; i++) frm.push_back(8'($urandom));
      if (good) begin
        frm[0] = 8'hFF;
        if (n > 1) frm[1] = 8'h03;
      end
      send_frame(1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), "R4");
    end
    drain();
    rand_ready = 1'b0;
    repeat (3) @(posedge clk);
    chk(irq_seen == irq_exp, "R3", "irq pulse total", irq_seen, irq_exp);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule